// File: doc/BRIEF.md
# Quad Serial DAC Host Sequencer

This block sits on the host side of a four-channel, 12-bit serial DAC with double-buffered registers. It takes one command at a time over a valid/ready handshake. A command carries a channel number, a 12-bit code and an update-now flag. For each command the block sends a 16-bit word on the serial lines. It then pulses the load strobe so that the word is written into the input register of the chosen channel. If the update-now flag is set, it also pulses the transfer strobe, which moves all four input registers to the outputs at the same moment.

Two further requests are served only while the block is idle. A transfer request gives a standalone transfer pulse, so that several channels loaded earlier change together. A reset request gives a single reset pulse, with the reset-level select driven ahead of it.

Every minimum pulse width and setup time is a nanosecond parameter. The block converts each one to a count of system clocks, rounding up. With the default 10 ns clock the phases are:

| Phase | Cycles |
|---|---|
| First clock-low phase | 6 |
| Clock high | 3 |
| Clock low | 5 |
| Tail after the 16th rising edge | 3 |
| Load pulse | 5 |
| Transfer pulse | 5 |
| Reset-select lead | 3 |
| Reset pulse | 7 |

Top module: `qdac_host_ctrl`

## Requirements
- R1: Each frame has exactly 16 serial-clock rising edges while select is low. The bits go out in this order: channel bit 1, channel bit 0, two zero bits, then code bits 11 down to 0. Word bits [15:14] hold the channel and bits [11:0] hold the code.
- R2: The minimum timings on the serial lines are met.
  - Each serial-clock low phase lasts at least 50 ns.
  - Each high phase lasts at least 30 ns.
  - Data is stable at least 25 ns before each rising edge.
  - Data does not change within 20 ns after a rising edge, and never while the serial clock is high.
- R3: The rules on select are met.
  - Select falls at least 55 ns before the first rising edge.
  - Select rises at least 15 ns after the last rising edge.
  - Select rises only while the serial clock is high.
- R4: The rules on the load strobe are met.
  - The load strobe stays high while select is low, and for at least 40 ns before every rising edge.
  - It falls in the same cycle that select rises, at least 15 ns after the last rising edge.
  - It stays low for at least 45 ns.
  - There is exactly one load pulse per command.
- R5: A command with update-now set is followed by one transfer pulse of at least 45 ns after its load pulse. A command with update-now clear gives no transfer pulse.
- R6: A transfer request in idle gives one transfer pulse of at least 45 ns and no frame.
- R7: A reset request in idle works as follows.
  - The reset-level select output takes the requested level at least 25 ns before the reset output falls.
  - The reset output stays low for at least 70 ns.
  - The reset-level select output holds its level during the pulse and afterwards.
  - No frame is sent.
- R8: Ready falls in the cycle after a handshake and stays low until the last pulse has ended.
  - With update-now clear, ready is low for FIRST + 15·(HIGH+LOW) + HIGH + TAIL + LOAD cycles, which is 137 at the defaults.
  - With update-now set, the transfer pulse adds XFR cycles, which gives 142 at the defaults.
- R9: In idle and after reset, these outputs are all high: serial clock, select, load, transfer and reset. The reset-level select output is low after reset, and ready is high.
- R10: When requests arrive together in idle, a reset request wins over a command, and a command wins over a transfer request. A losing request that is withdrawn before the block returns to idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_chan | input | 2 | Target channel 0..3 |
| cmd_code | input | 12 | 12-bit output code |
| cmd_update | input | 1 | Transfer all channels after loading |
| ldac_strobe | input | 1 | Request a standalone transfer pulse |
| rst_req | input | 1 | Request a reset pulse to the DAC |
| rst_mid | input | 1 | Reset level to select: 1 = mid-scale, 0 = zero |
| dac_cs_n | output | 1 | Serial select, active low |
| dac_sclk | output | 1 | Serial clock, rests high |
| dac_sdo | output | 1 | Serial data toward the DAC |
| dac_load_n | output | 1 | Input-register load strobe, active low |
| dac_ldac_n | output | 1 | Transfer-all strobe, active low |
| dac_rst_n | output | 1 | DAC reset, active low |
| dac_rstsel | output | 1 | DAC reset-level select |

## Verification
Every output of the block is a decode of a registered state, so each pin moves on the clock edge that changes the phase. The bench samples on falling edges and stamps each pin transition with a cycle count. Pulse widths and setups are checked as cycle differences times 10 ns against the nanosecond minimums.

The ready-low window has a known length: 137 or 142 cycles at the defaults. The bench counts it from the first falling edge after the handshake. It checks the frame contents and the pulse counts only two cycles after ready returns, so the monitor has already recorded the last strobe edge.

// File: rtl/qdac_host_ctrl.sv
module qdac_host_ctrl #(
  parameter int SYS_PERIOD_NS = 10,
  parameter int T_SETUP_NS    = 25,
  parameter int T_HOLD_NS     = 20,
  parameter int T_CLKHI_NS    = 30,
  parameter int T_CLKLO_NS    = 50,
  parameter int T_SELLEAD_NS  = 55,
  parameter int T_SELLAG_NS   = 15,
  parameter int T_LDLEAD_NS   = 40,
  parameter int T_LDLAG_NS    = 15,
  parameter int T_LDPULSE_NS  = 45,
  parameter int T_XFRPULSE_NS = 45,
  parameter int T_RSTLEAD_NS  = 25,
  parameter int T_RSTPULSE_NS = 70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_chan,
  input  logic [11:0] cmd_code,
  input  logic        cmd_update,
  input  logic        ldac_strobe,
  input  logic        rst_req,
  input  logic        rst_mid,
  output logic        dac_cs_n,
  output logic        dac_sclk,
  output logic        dac_sdo,
  output logic        dac_load_n,
  output logic        dac_ldac_n,
  output logic        dac_rst_n,
  output logic        dac_rstsel
);

  function automatic int ns2c(input int ns);
    int c;
    c = (ns + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int FRAME_BITS = 16;
  localparam int N_LOW   = mx(ns2c(T_CLKLO_NS), ns2c(T_SETUP_NS));
  localparam int N_HIGH  = mx(ns2c(T_CLKHI_NS), ns2c(T_HOLD_NS));
  localparam int N_FIRST = mx(N_LOW, mx(ns2c(T_SELLEAD_NS), ns2c(T_LDLEAD_NS)));
  localparam int N_TAIL  = mx(N_HIGH, mx(ns2c(T_SELLAG_NS), ns2c(T_LDLAG_NS)));
  localparam int N_LOAD  = ns2c(T_LDPULSE_NS);
  localparam int N_XFR   = ns2c(T_XFRPULSE_NS);
  localparam int N_RSET  = ns2c(T_RSTLEAD_NS);
  localparam int N_RLOW  = ns2c(T_RSTPULSE_NS);
  localparam int N_MAX   = mx(mx(mx(N_FIRST, N_TAIL), mx(N_LOAD, N_XFR)), mx(N_RSET, N_RLOW));
  localparam int CW      = $clog2(N_MAX) + 1;
  localparam int BW      = $clog2(FRAME_BITS);

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_HIGH, S_LOW, S_TAIL, S_LOAD, S_XFR, S_RSET, S_RLOW
  } state_t;

  state_t                  st;
  logic [CW-1:0]           cnt;
  logic [BW-1:0]           nbit;
  logic [FRAME_BITS-1:0]   shreg;
  logic                    upd;
  logic                    sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      shreg <= '0;
      upd   <= 1'b0;
      sel_q <= 1'b0;
    end else if (st == S_IDLE) begin
      if (rst_req) begin
        st    <= S_RSET;
        cnt   <= CW'(N_RSET - 1);
        sel_q <= rst_mid;
      end else if (cmd_valid) begin
        st    <= S_FIRST;
        cnt   <= CW'(N_FIRST - 1);
        shreg <= {cmd_chan, 2'b00, cmd_code};
        upd   <= cmd_update;
        nbit  <= '0;
      end else if (ldac_strobe) begin
        st  <= S_XFR;
        cnt <= CW'(N_XFR - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      case (st)
        S_FIRST, S_LOW: begin
          st  <= S_HIGH;
          cnt <= CW'(N_HIGH - 1);
        end
        S_HIGH: begin
          if (nbit == BW'(FRAME_BITS - 1)) begin
            st  <= S_TAIL;
            cnt <= CW'(N_TAIL - 1);
          end else begin
            st    <= S_LOW;
            cnt   <= CW'(N_LOW - 1);
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            nbit  <= nbit + 1'b1;
          end
        end
        S_TAIL: begin
          st  <= S_LOAD;
          cnt <= CW'(N_LOAD - 1);
        end
        S_LOAD: begin
          if (upd) begin
            st  <= S_XFR;
            cnt <= CW'(N_XFR - 1);
          end else begin
            st <= S_IDLE;
          end
        end
        S_RSET: begin
          st  <= S_RLOW;
          cnt <= CW'(N_RLOW - 1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (st == S_IDLE) && !rst_req;
  assign dac_sclk   = !(st == S_FIRST || st == S_LOW);
  assign dac_cs_n   = !(st == S_FIRST || st == S_LOW || st == S_HIGH || st == S_TAIL);
  assign dac_sdo    = shreg[FRAME_BITS-1];
  assign dac_load_n = (st != S_LOAD);
  assign dac_ldac_n = (st != S_XFR);
  assign dac_rst_n  = (st != S_RLOW);
  assign dac_rstsel = sel_q;

  AST_CS_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> dac_sclk); // R3
  AST_LOAD_HIGH_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> dac_load_n); // R4
  AST_LOAD_WITH_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_load_n) |-> $rose(dac_cs_n)); // R4
  AST_SDI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && dac_sclk && $past(dac_sclk) && !$past(dac_cs_n)) |-> $stable(dac_sdo)); // R2
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R8
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (dac_cs_n && dac_sclk && dac_load_n && dac_ldac_n && dac_rst_n)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dac_load_n, !dac_ldac_n, !dac_rst_n})); // R5
  AST_RSTSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_rst_n |-> $stable(dac_rstsel)); // R7

endmodule

// File: tb/qdac_host_ctrl_tb.sv
module qdac_host_ctrl_tb;
  localparam int PER = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_update, ldac_strobe, rst_req, rst_mid;
  logic [1:0] cmd_chan;
  logic [11:0] cmd_code;
  logic dac_cs_n, dac_sclk, dac_sdo, dac_load_n, dac_ldac_n, dac_rst_n, dac_rstsel;

  qdac_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_code(cmd_code), .cmd_update(cmd_update),
    .ldac_strobe(ldac_strobe), .rst_req(rst_req), .rst_mid(rst_mid),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
    .dac_load_n(dac_load_n), .dac_ldac_n(dac_ldac_n), .dac_rst_n(dac_rst_n),
    .dac_rstsel(dac_rstsel)
  );

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NL = mx(cdiv(50), cdiv(25));
  localparam int NH = mx(cdiv(30), cdiv(20));
  localparam int NF = mx(NL, mx(cdiv(55), cdiv(40)));
  localparam int NT = mx(NH, mx(cdiv(15), cdiv(15)));
  localparam int NLD = cdiv(45);
  localparam int NX = cdiv(45);
  localparam int NRS = cdiv(25);
  localparam int NRL = cdiv(70);
  localparam int FRAME_CYC = NF + 15 * (NH + NL) + NH + NT + NLD;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor and DAC model
  int cyc = 0;
  int t_sr = -1000, t_sf = -1000, t_sdi = -1000, t_csf = -1000, t_ldr = -1000, t_ldf = -1000;
  int t_xf = -1000, t_rs = -1000, t_rf = -1000;
  int nb = 0, frames = 0, loads = 0, xfrs = 0, rsts = 0;
  logic [15:0] word = '0, last_word = '0;
  logic [11:0] inreg [4];
  logic [11:0] dacreg [4];
  logic p_sclk = 1, p_cs = 1, p_sdo = 0, p_ld = 1, p_xf = 1, p_rst = 1, p_sel = 0;

  initial for (int i = 0; i < 4; i++) begin inreg[i] = '0; dacreg[i] = '0; end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dac_sdo != p_sdo) begin
        if (!dac_cs_n) chk((cyc - t_sr) * PER >= 20, "R2 hold", (cyc - t_sr) * PER, 20);
        t_sdi = cyc;
      end
      if (!dac_cs_n && p_cs) begin t_csf = cyc; nb = 0; frames++; end
      if (dac_sclk && !p_sclk && !dac_cs_n) begin
        if (nb == 0) chk((cyc - t_csf) * PER >= 55, "R3 lead", (cyc - t_csf) * PER, 55);
        chk((cyc - t_sf) * PER >= 50, "R2 low", (cyc - t_sf) * PER, 50);
        chk((cyc - t_sdi) * PER >= 25, "R2 setup", (cyc - t_sdi) * PER, 25);
        chk(dac_load_n && (cyc - t_ldr) * PER >= 40, "R4 lead", (cyc - t_ldr) * PER, 40);
        word = {word[14:0], dac_sdo};
        nb++;
      end
      if (dac_sclk && !p_sclk) t_sr = cyc;
      if (!dac_sclk && p_sclk) begin
        chk((cyc - t_sr) * PER >= 30, "R2 high", (cyc - t_sr) * PER, 30);
        t_sf = cyc;
      end
      if (dac_cs_n && !p_cs) begin
        chk(dac_sclk, "R3 clk high at deselect", dac_sclk, 1);
        chk((cyc - t_sr) * PER >= 15, "R3 lag", (cyc - t_sr) * PER, 15);
        chk(nb == 16, "R1 edges", nb, 16);
        last_word = word;
      end
      if (!dac_load_n && p_ld) begin
        chk(dac_cs_n, "R4 load after deselect", dac_cs_n, 1);
        chk((cyc - t_sr) * PER >= 15, "R4 lag", (cyc - t_sr) * PER, 15);
        t_ldf = cyc;
      end
      if (dac_load_n && !p_ld) begin
        chk((cyc - t_ldf) * PER >= 45, "R4 width", (cyc - t_ldf) * PER, 45);
        inreg[last_word[15:14]] = last_word[11:0];
        loads++;
        t_ldr = cyc;
      end
      if (!dac_ldac_n && p_xf) begin
        t_xf = cyc;
        for (int i = 0; i < 4; i++) dacreg[i] = inreg[i];
        xfrs++;
      end
      if (dac_ldac_n && !p_xf) chk((cyc - t_xf) * PER >= 45, "R5 width", (cyc - t_xf) * PER, 45);
      if (dac_rstsel != p_sel) t_rs = cyc;
      if (!dac_rst_n && p_rst) begin
        chk((cyc - t_rs) * PER >= 25, "R7 select lead", (cyc - t_rs) * PER, 25);
        t_rf = cyc;
      end
      if (dac_rst_n && !p_rst) begin
        chk((cyc - t_rf) * PER >= 70, "R7 width", (cyc - t_rf) * PER, 70);
        for (int i = 0; i < 4; i++) begin
          inreg[i] = dac_rstsel ? 12'h800 : 12'h000;
          dacreg[i] = inreg[i];
        end
        rsts++;
      end
    end
    p_sclk = dac_sclk; p_cs = dac_cs_n; p_sdo = dac_sdo; p_ld = dac_load_n;
    p_xf = dac_ldac_n; p_rst = dac_rst_n; p_sel = dac_rstsel;
  end

  task automatic send(input logic [1:0] ch, input logic [11:0] code, input logic upd);
    int n, l0, x0;
    l0 = loads; x0 = xfrs;
    @(negedge clk);
    cmd_valid = 1; cmd_chan = ch; cmd_code = code; cmd_update = upd;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    n = 0;
    while (!cmd_ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == FRAME_CYC + (upd ? NX : 0), "R8 busy window", n, FRAME_CYC + (upd ? NX : 0));
    repeat (2) @(negedge clk);
    chk(last_word == {ch, 2'b00, code}, "R1 word", last_word, {ch, 2'b00, code});
    chk(loads == l0 + 1, "R4 one load", loads - l0, 1);
    chk(xfrs == x0 + (upd ? 1 : 0), "R5 transfer count", xfrs - x0, upd ? 1 : 0);
    if (upd) chk(dacreg[ch] == code, "R5 output updated", dacreg[ch], code);
  endtask

  task automatic strobe_xfr();
    int f0, x0, l0;
    f0 = frames; x0 = xfrs; l0 = loads;
    @(negedge clk); ldac_strobe = 1;
    @(negedge clk); ldac_strobe = 0;
    repeat (NX + 3) @(negedge clk);
    chk(xfrs == x0 + 1, "R6 transfer pulse", xfrs - x0, 1);
    chk(frames == f0 && loads == l0, "R6 no frame", frames - f0, 0);
  endtask

  task automatic dac_reset(input logic mid);
    int f0, r0;
    f0 = frames; r0 = rsts;
    @(negedge clk); rst_req = 1; rst_mid = mid;
    @(negedge clk); rst_req = 0;
    repeat (NRS + NRL + 3) @(negedge clk);
    chk(rsts == r0 + 1, "R7 reset pulse", rsts - r0, 1);
    chk(dac_rstsel == mid, "R7 select level", dac_rstsel, mid);
    chk(frames == f0, "R7 no frame", frames - f0, 0);
    chk(dacreg[0] == (mid ? 12'h800 : 12'h000), "R7 model level", dacreg[0], mid ? 12'h800 : 0);
  endtask

  task automatic priority_test();
    int f0, r0, x0, l0;
    f0 = frames; r0 = rsts; x0 = xfrs;
    @(negedge clk); rst_req = 1; rst_mid = 1; cmd_valid = 1; cmd_chan = 2'd1; cmd_code = 12'h123; cmd_update = 1; ldac_strobe = 1;
    @(negedge clk); rst_req = 0; cmd_valid = 0; ldac_strobe = 0;
    chk(!cmd_ready, "R10 reset wins, ready low", cmd_ready, 0);
    repeat (NRS + NRL + 5) @(negedge clk);
    chk(rsts == r0 + 1 && frames == f0 && xfrs == x0, "R10 only reset served", rsts - r0, 1);
    l0 = loads; x0 = xfrs; f0 = frames;
    @(negedge clk); cmd_valid = 1; cmd_chan = 2'd0; cmd_code = 12'h5A5; cmd_update = 0; ldac_strobe = 1;
    @(negedge clk); cmd_valid = 0; ldac_strobe = 0;
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(loads == l0 + 1 && frames == f0 + 1, "R10 command wins", loads - l0, 1);
    chk(xfrs == x0, "R10 strobe dropped", xfrs - x0, 0);
    chk(inreg[0] == 12'h5A5 && dacreg[0] == 12'h800, "R10 outputs untouched", dacreg[0], 12'h800);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_chan = 0; cmd_code = 0; cmd_update = 0;
    ldac_strobe = 0; rst_req = 0; rst_mid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dac_cs_n && dac_sclk && dac_load_n && dac_ldac_n && dac_rst_n, "R9 idle levels",
        {dac_cs_n, dac_sclk, dac_load_n, dac_ldac_n, dac_rst_n}, 5'h1f);
    chk(cmd_ready == 1, "R9 ready", cmd_ready, 1);
    chk(dac_rstsel == 0, "R9 reset select", dac_rstsel, 0);

    send(2'd2, 12'hA5C, 1'b0);
    chk(dacreg[2] == 12'h000, "R5 no update without flag", dacreg[2], 0);
    send(2'd1, 12'h3FF, 1'b0);
    strobe_xfr();
    chk(dacreg[2] == 12'hA5C && dacreg[1] == 12'h3FF, "R6 joint update", dacreg[2], 12'hA5C);
    send(2'd3, 12'hFFF, 1'b1);
    send(2'd0, 12'h000, 1'b0);
    send(2'd0, 12'h801, 1'b1);
    dac_reset(1'b1);
    dac_reset(1'b0);
    priority_test();
    @(negedge clk);
    chk(dac_cs_n && dac_sclk && dac_load_n && dac_ldac_n && dac_rst_n && cmd_ready, "R9 idle after work",
        cmd_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule